// File: doc/BRIEF.md
# Per-CPU Interrupt Routing Controller

This block gathers level-sensitive peripheral interrupt requests and steers each one onto one of several interrupt lines of every processor. Each processor owns a private bank of registers: an enable mask, a read-only view of the synchronized request levels, and a set of routing words that give every request a small code. The code picks the output line for that request in that bank, or leaves the request unconnected.

Software programs the banks through a plain word-wide register bus. The upper address bits pick the bank and the lower bits pick the register. A request reaches a line of a processor only while it is high, enabled in that processor's mask and routed to that line in that processor's bank. Requests are levels, so a line stays high for as long as a qualifying request stays high. Software clears the request at the peripheral.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every mask and routing field is zero, every output line is low, and the read data port is zero.
- R2: The mask register sits at byte offset 0x00 of a bank. A full-word write stores one enable bit per request (bit i for request i), and a later read returns the stored word.
- R3: Offset 0x04 returns the request levels after a two-flop synchronizer (bit i for request i), so an input change shows up two clock edges later. A write to this offset changes no register.
- R4: Routing words sit at offsets 0x08, 0x0C, 0x10 and 0x14, in reversed order: 0x08 holds requests 24–31, 0x0C holds 16–23, 0x10 holds 8–15 and 0x14 holds 0–7. Request i uses bits [4·(i mod 8)+3 : 4·(i mod 8)] of its word. Reads return the stored fields.
- R5: A routing code of 0 leaves a request disconnected. A code v in 1..15 sends it to output line v−1.
- R6: Line k of processor c is high one edge after the synchronized status shows a request that is high, enabled in bank c and routed with code k+1. The line stays high while such a request remains.
- R7: A request whose mask bit is 0 in a bank contributes to no line of that processor.
- R8: The bank is selected by address bits [7:5]. Banks 0 and 1 are independent copies, and a write to one never changes the other. Output line k of processor c is irq_out[15·c+k].
- R9: Read data is registered. It updates on the edge that samples bus_rd and holds until the next read. A read of a bank number of 2 or more, of an unused offset, or of an address whose low two bits are not zero returns 0. A write to any such address changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive peripheral requests |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address: bank in [7:5], register in [4:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 30 | Output lines, 15 per processor |

## Verification
The routing path is driven with single requests, routed first to the lowest line and then to the highest, so that an off-by-one between code and line shows up at once. It is also driven with code 0 under a full mask, which separates a disconnected request from a merely masked one. The same request is then routed differently in the two banks, which shows whether the banks share storage or outputs. A long phase with pseudo-random request levels and random register writes mixes several requests onto one line, together with mask changes while they are high. Here the behavioural model shows whether the line follows the level on the right cycle, and whether a status write or a write to an unused or misaligned address disturbs any state.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   // register word indices inside one bank (byte offset = index * 4)
   localparam int IDX_MASK    = 0;
   localparam int IDX_STATUS  = 1;
   localparam int IDX_RT_BASE = 2;

   // first request held by routing word w (words run from high requests down)
   function automatic int word_first_req(input int w, input int n_words, input int fpw);
      return (n_words - 1 - w) * fpw;
   endfunction
endpackage

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] pipe;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("irq_level_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[0] <= '0;
               else        pipe[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[s] <= '0;
               else        pipe[s] <= pipe[s-1];
            end
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/irq_bank_regs.sv
module irq_bank_regs
   import irq_route_pkg::*;
#(
   parameter int N_IN    = 32,
   parameter int CODE_W  = 4,
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         idx,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [N_IN-1:0]          level,
   output logic [N_IN-1:0]          mask_q,
   output logic [N_IN*CODE_W-1:0]   code_flat,
   output logic [DATA_W-1:0]        rd_word
);
   localparam int FPW     = DATA_W / CODE_W;
   localparam int N_WORDS = N_IN / FPW;

   logic [N_IN-1:0][CODE_W-1:0]    code_q;
   logic [N_WORDS-1:0][DATA_W-1:0] rt_word;

   // enable mask
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (wr_en && idx == IDX_W'(IDX_MASK))
         mask_q <= wdata[N_IN-1:0];
   end

   // routing fields, one register per request
   generate
      for (genvar i = 0; i < N_IN; i++) begin : g_code
         localparam int WI = N_WORDS - 1 - (i / FPW);
         localparam int JI = i % FPW;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               code_q[i] <= '0;
            else if (wr_en && idx == IDX_W'(IDX_RT_BASE + WI))
               code_q[i] <= wdata[JI*CODE_W +: CODE_W];
         end
      end

      for (genvar w = 0; w < N_WORDS; w++) begin : g_word
         for (genvar j = 0; j < FPW; j++) begin : g_field
            assign rt_word[w][j*CODE_W +: CODE_W] =
               code_q[word_first_req(w, N_WORDS, FPW) + j];
         end
      end
   endgenerate

   assign code_flat = code_q;

   always_comb begin
      rd_word = '0;
      if (idx == IDX_W'(IDX_MASK))
         rd_word = DATA_W'(mask_q);
      else if (idx == IDX_W'(IDX_STATUS))
         rd_word = DATA_W'(level);
      for (int w = 0; w < N_WORDS; w++) begin
         if (idx == IDX_W'(IDX_RT_BASE + w))
            rd_word = rt_word[w];
      end
   end

   // R2
   mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == IDX_W'(IDX_MASK)) |=> mask_q == $past(wdata[N_IN-1:0]));

   // R3
   status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == IDX_W'(IDX_STATUS)) |=> ($stable(mask_q) && $stable(code_flat)));
endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
   parameter int N_IN   = 32,
   parameter int N_OUT  = 15,
   parameter int CODE_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_IN-1:0]        level,
   input  logic [N_IN-1:0]        mask,
   input  logic [N_IN*CODE_W-1:0] code_flat,
   output logic [N_OUT-1:0]       line_q
);
   logic [N_IN-1:0]             armed;
   logic [N_OUT-1:0][N_IN-1:0]  pick;
   logic [N_OUT-1:0]            hit;

   assign armed = level & mask;

   generate
      for (genvar k = 0; k < N_OUT; k++) begin : g_line
         for (genvar i = 0; i < N_IN; i++) begin : g_req
            assign pick[k][i] = armed[i] &&
               (code_flat[i*CODE_W +: CODE_W] == CODE_W'(k + 1));
         end
         assign hit[k] = |pick[k];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= '0;
      else        line_q <= hit;
   end

   // R7
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |=> (line_q == '0));

   // R6
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0) |=> (line_q == '0));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
   import irq_route_pkg::*;
#(
   parameter int N_IN        = 32,
   parameter int N_OUT       = 15,
   parameter int N_CPU       = 2,
   parameter int CODE_W      = 4,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_IN-1:0]         irq_in,
   input  logic                    bus_wr,
   input  logic                    bus_rd,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   output logic [N_CPU*N_OUT-1:0]  irq_out
);
   localparam int FPW      = DATA_W / CODE_W;
   localparam int N_WORDS  = N_IN / FPW;
   localparam int N_IDX    = IDX_RT_BASE + N_WORDS;
   localparam int IDX_W    = $clog2(N_IDX);
   localparam int BANK_LSB = IDX_W + 2;
   localparam int BSEL_W   = ADDR_W - BANK_LSB;

   generate
      if (N_OUT > (1 << CODE_W) - 1) begin : g_bad_out
         $error("irq_route_ctrl: N_OUT exceeds the nonzero routing codes");
      end
      if (DATA_W % CODE_W != 0 || N_IN % FPW != 0 || N_IN > DATA_W) begin : g_bad_pack
         $error("irq_route_ctrl: requests do not pack into whole routing words");
      end
      if (BSEL_W < 1 || (1 << BSEL_W) < N_CPU) begin : g_bad_addr
         $error("irq_route_ctrl: ADDR_W too narrow for the bank select");
      end
   endgenerate

   logic [N_IN-1:0]          status;
   logic [BSEL_W-1:0]        bank_sel;
   logic [IDX_W-1:0]         reg_idx;
   logic                     aligned;
   logic [DATA_W-1:0]        sel_word;
   logic [N_CPU-1:0][DATA_W-1:0] bank_rd;

   assign bank_sel = bus_addr[ADDR_W-1:BANK_LSB];
   assign reg_idx  = bus_addr[BANK_LSB-1:2];
   assign aligned  = (bus_addr[1:0] == 2'b00);

   irq_level_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_in),
      .q     (status)
   );

   generate
      for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
         logic                   wr_c;
         logic [N_IN-1:0]        mask_c;
         logic [N_IN*CODE_W-1:0] code_c;

         assign wr_c = bus_wr && aligned && (bank_sel == BSEL_W'(c));

         irq_bank_regs #(
            .N_IN(N_IN), .CODE_W(CODE_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
         ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_c),
            .idx       (reg_idx),
            .wdata     (bus_wdata),
            .level     (status),
            .mask_q    (mask_c),
            .code_flat (code_c),
            .rd_word   (bank_rd[c])
         );

         irq_line_merge #(.N_IN(N_IN), .N_OUT(N_OUT), .CODE_W(CODE_W)) u_merge (
            .clk       (clk),
            .rst_n     (rst_n),
            .level     (status),
            .mask      (mask_c),
            .code_flat (code_c),
            .line_q    (irq_out[c*N_OUT +: N_OUT])
         );
      end
   endgenerate

   always_comb begin
      sel_word = '0;
      if (aligned) begin
         for (int c = 0; c < N_CPU; c++) begin
            if (bank_sel == BSEL_W'(c))
               sel_word = bank_rd[c];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= sel_word;
   end

   // R9
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (!aligned || 32'(bank_sel) >= N_CPU)) |=> (bus_rdata == '0));

   // R9
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/irq_route_ctrl_bench.sv
module irq_route_ctrl_bench;
   localparam int NI = 32, NO = 15, NC = 2;
   localparam int TIMEOUT_CYC = 150000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [31:0]  irq_in = '0;
   logic         bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]   bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [29:0]  irq_out;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_route_ctrl u_irq_route_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   // ---------------- behavioural reference model ----------------
   logic [31:0] mask_m [NC];
   logic [3:0]  rt_m   [NC][NI];
   logic [31:0] s1_m, s2_m, rd_m;
   logic [29:0] out_m;

   function automatic logic [31:0] model_read(input logic [7:0] a);
      int b, x, first;
      logic [31:0] r;
      b = int'(a[7:5]); x = int'(a[4:2]); r = '0;
      if (a[1:0] != 2'b00 || b >= NC) return '0;
      if (x == 0) return mask_m[b];
      if (x == 1) return s2_m;
      if (x >= 2 && x <= 5) begin
         first = (3 - (x - 2)) * 8;
         for (int j = 0; j < 8; j++) r[4*j +: 4] = rt_m[b][first + j];
      end
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NC; c++) begin
            mask_m[c] = '0;
            for (int i = 0; i < NI; i++) rt_m[c][i] = '0;
         end
         s1_m = '0; s2_m = '0; rd_m = '0; out_m = '0;
      end else begin
         for (int c = 0; c < NC; c++)
            for (int k = 0; k < NO; k++) begin
               out_m[c*NO + k] = 1'b0;
               for (int i = 0; i < NI; i++)
                  if (s2_m[i] && mask_m[c][i] && rt_m[c][i] == 4'(k + 1))
                     out_m[c*NO + k] = 1'b1;
            end
         if (bus_rd) rd_m = model_read(bus_addr);
         if (bus_wr && bus_addr[1:0] == 2'b00 && int'(bus_addr[7:5]) < NC) begin
            int b, x;
            b = int'(bus_addr[7:5]); x = int'(bus_addr[4:2]);
            if (x == 0) mask_m[b] = bus_wdata;
            else if (x >= 2 && x <= 5)
               for (int j = 0; j < 8; j++) rt_m[b][(3 - (x - 2)) * 8 + j] = bus_wdata[4*j +: 4];
         end
         s2_m = s1_m;
         s1_m = irq_in;
      end
   end

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (irq_out !== out_m) begin
            errors++;
            $display("FAIL R6 irq_out actual=%h expected=%h at %0t", irq_out, out_m, $time);
         end
         checks++;
         if (bus_rdata !== rd_m) begin
            errors++;
            $display("FAIL R9 bus_rdata actual=%h expected=%h at %0t", bus_rdata, rd_m, $time);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input int bank, input logic [7:0] off, input logic [31:0] d);
      @(negedge clk);
      bus_addr = 8'(bank << 5) | off; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input int bank, input logic [7:0] off, output logic [31:0] d);
      @(negedge clk);
      bus_addr = 8'(bank << 5) | off; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic line(input int c, input int k);
      return irq_out[c*NO + k];
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      repeat (TIMEOUT_CYC) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // ---------------- directed and random stimulus ----------------
   initial begin
      logic [31:0] rv;
      logic [31:0] lfsr;
      lfsr = 32'hACE1_2468;

      repeat (3) @(negedge clk);
      // R1: state during and right after reset
      check("R1 irq_out in reset", 32'(irq_out), 32'h0);
      check("R1 rdata in reset", bus_rdata, 32'h0);
      rst_n = 1'b1;
      bus_read(0, 8'h00, rv); check("R1 mask bank0", rv, 32'h0);
      bus_read(1, 8'h08, rv); check("R1 route word bank1", rv, 32'h0);

      // R2: mask store and readback
      bus_write(0, 8'h00, 32'hA5C3_0F81);
      bus_read(0, 8'h00, rv); check("R2 mask readback", rv, 32'hA5C3_0F81);
      // R8: other bank untouched
      bus_read(1, 8'h00, rv); check("R8 bank1 mask untouched", rv, 32'h0);

      // R4: reversed routing words
      bus_write(0, 8'h08, 32'h3000_0000);   // request 31 -> code 3
      bus_write(0, 8'h14, 32'h0000_0001);   // request 0  -> code 1
      bus_read(0, 8'h08, rv); check("R4 word 0x08", rv, 32'h3000_0000);
      bus_read(0, 8'h14, rv); check("R4 word 0x14", rv, 32'h0000_0001);
      bus_read(0, 8'h10, rv); check("R4 word 0x10", rv, 32'h0);

      // R5/R6: request 31 -> line 2; check latency of three edges
      bus_write(0, 8'h00, 32'hFFFF_FFFF);
      @(negedge clk); irq_in[31] = 1'b1;
      idle(2); check("R6 not yet high", 32'(line(0, 2)), 32'h0);
      idle(1); check("R5 code3 drives line2", 32'(line(0, 2)), 32'h1);
      check("R8 bank1 quiet", 32'(irq_out[29:15]), 32'h0);
      idle(5); check("R6 level held", 32'(line(0, 2)), 32'h1);

      // R3: status readback and write ignored
      bus_read(0, 8'h04, rv); check("R3 status", rv, 32'h8000_0000);
      bus_write(0, 8'h04, 32'h0000_FFFF);
      bus_read(0, 8'h00, rv); check("R3 status write left mask", rv, 32'hFFFF_FFFF);
      bus_read(0, 8'h08, rv); check("R3 status write left route", rv, 32'h3000_0000);

      // R7: masking drops the line
      bus_write(0, 8'h00, 32'h7FFF_FFFF);
      idle(1); check("R7 masked request", 32'(line(0, 2)), 32'h0);

      // R5: code 0 disconnects; request 0 code 1 -> line 0
      @(negedge clk); irq_in = 32'h0000_0021;   // requests 0 and 5
      idle(4);
      check("R5 code1 drives line0", 32'(irq_out[14:0]), 32'h0001);
      // R5: code 15 -> line 14 (request 5 sits in word 0x14 bits 23:20)
      bus_write(0, 8'h14, 32'h00F0_0001);
      idle(1);
      check("R5 code15 drives line14", 32'(irq_out[14:0]), 32'h4001);

      // R8: bank1 routes request 31 to line 7, bank0 keeps it masked
      @(negedge clk); irq_in = 32'h8000_0000;
      bus_write(1, 8'h00, 32'h8000_0000);
      bus_write(1, 8'h08, 32'h8000_0000);
      idle(4);
      check("R8 bank1 line7", 32'(irq_out[29:15]), 32'h0080);
      check("R8 bank0 quiet", 32'(irq_out[14:0]), 32'h0);

      // R9: unmapped, out-of-range bank and misaligned accesses
      bus_read(2, 8'h00, rv); check("R9 bank2 read", rv, 32'h0);
      bus_read(0, 8'h1C, rv); check("R9 unused offset", rv, 32'h0);
      bus_write(1, 8'h02, 32'h0);
      bus_read(1, 8'h00, rv); check("R9 misaligned write ignored", rv, 32'h8000_0000);
      idle(2); check("R9 rdata held", bus_rdata, 32'h8000_0000);

      // mixed phase: pseudo-random levels and register traffic
      for (int n = 0; n < 3000; n++) begin
         @(negedge clk);
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         if (lfsr[3:0] == 4'h0) irq_in = lfsr ^ {lfsr[15:0], lfsr[31:16]};
         bus_wr = 1'b0; bus_rd = 1'b0;
         if (lfsr[7:5] == 3'd1) begin
            bus_wr = 1'b1;
            bus_addr = {lfsr[10:8] == 3'd7 ? 3'd2 : {2'b0, lfsr[11]},
                        lfsr[14:12], lfsr[15] & lfsr[16], 1'b0};
            bus_wdata = {lfsr[15:0], lfsr[31:16]};
         end else if (lfsr[7:5] == 3'd2) begin
            bus_rd = 1'b1;
            bus_addr = {2'b0, lfsr[11], lfsr[14:12], 1'b0, lfsr[17] & lfsr[18]};
         end
      end
      @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
      idle(4);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule